// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block sits in the address stage of a RISC load/store pipeline. Each cycle it can accept one request. A request carries a mode code, two register specifiers with the operand values already read for them, a signed immediate and a shift amount. From these the block forms the memory address. In the two update modes it also asks for the new address to be written back into the base register.

Operand values pass through a small read model before any arithmetic. In that model, specifier 0 is the zero register: it reads as zero whatever value arrives on the data input. With the zero register as base and an immediate, software gets an absolute address of limited range. An immediate of zero turns the displacement mode into plain register-indirect access, so no separate mode is needed for it. All sums are 32 bits wide and wrap. The block registers every result and presents it one cycle after the request, with a valid flag.

Top module: `lsu_agen`

## Requirements
- R1: Mode 3'b000 (displacement) gives addr_o = base + sign-extended imm_i, where imm_i bit 15 is the sign bit.
- R2: Mode 3'b001 (indexed) gives addr_o = base + index.
- R3: Mode 3'b010 (scaled) gives addr_o = base + (index << shamt_i), for any shamt_i from 0 to 31.
- R4: Mode 3'b011 (displacement with update) computes the same address as R1. It also drives wb_en_o=1, wb_idx_o=base_idx_i and wb_data_o equal to addr_o in the same cycle.
- R5: Mode 3'b100 (indexed with update) computes the same address as R2. It also drives wb_en_o=1, wb_idx_o=base_idx_i and wb_data_o equal to addr_o in the same cycle.
- R6: A specifier of 0 reads as zero on both the base and index operands, whatever the value on the matching data input.
- R7: In an update mode with base_idx_i=0, wb_en_o stays 0 and addr_o still carries the computed address.
- R8: Mode codes 3'b101, 3'b110 and 3'b111 set illegal_o=1, keep wb_en_o=0 and drive addr_o=0.
- R9: Address arithmetic wraps modulo 2^32, with no overflow indication.
- R10: A request taken with in_valid_i=1 appears on the outputs after the next rising clock edge, with out_valid_o=1. A cycle without in_valid_i gives out_valid_o=0 and wb_en_o=0. The non-update modes never assert wb_en_o.
- R11: While rst_ni is low, out_valid_o, wb_en_o and illegal_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A request is present this cycle |
| mode_i | input | 3 | Addressing mode code |
| base_idx_i | input | 5 | Base register specifier |
| base_val_i | input | 32 | Value read for the base specifier |
| index_idx_i | input | 5 | Index register specifier |
| index_val_i | input | 32 | Value read for the index specifier |
| imm_i | input | 16 | Signed displacement |
| shamt_i | input | 5 | Left shift applied to the index in scaled mode |
| out_valid_o | output | 1 | Result registers hold a new request |
| addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base register writeback request |
| wb_idx_o | output | 5 | Register to write back |
| wb_data_o | output | 32 | Updated base value |
| illegal_o | output | 1 | The mode code was not a defined mode |

## Verification
The hardest case to reach is a request where several effects meet at once. One example is an update-mode request whose base specifier is zero while the base data input carries a large nonzero value. Another is a scaled request with shift 31 whose sum wraps past 2^32. The stimulus sets up each of these on purpose, with garbage on the data inputs of zero specifiers. Requests run back to back and are broken by idle gaps, so the scoreboard also checks the valid alignment and that writeback stays off when nothing was accepted.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;

  typedef enum logic [2:0] {
    AM_DISP     = 3'b000,
    AM_INDEX    = 3'b001,
    AM_SCALED   = 3'b010,
    AM_DISP_UPD = 3'b011,
    AM_IDX_UPD  = 3'b100
  } amode_e;

  localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/lsu_agen_rf_read.sv
// Operand read model: specifier 0 is the hardwired zero register.
module lsu_agen_rf_read #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] idx_i,
  input  logic [XLEN-1:0]   val_i,
  output logic [XLEN-1:0]   data_o
);

  logic is_zero_reg;

  assign is_zero_reg = (idx_i == '0);
  assign data_o      = is_zero_reg ? '0 : val_i;

endmodule

// File: rtl/lsu_agen_calc.sv
module lsu_agen_calc
  import lsu_agen_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned SH_W  = $clog2(XLEN)
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   index_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [XLEN-1:0]   addr_o,
  output logic              legal_o,
  output logic              upd_o
);

  localparam int unsigned EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sext;
  logic [XLEN-1:0] idx_scaled;
  logic [XLEN-1:0] offset;

  assign imm_sext   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign idx_scaled = index_i << shamt_i;

  always_comb begin
    offset  = '0;
    legal_o = 1'b1;
    upd_o   = 1'b0;
    unique case (mode_i)
      AM_DISP:     offset = imm_sext;
      AM_INDEX:    offset = index_i;
      AM_SCALED:   offset = idx_scaled;
      AM_DISP_UPD: begin offset = imm_sext; upd_o = 1'b1; end
      AM_IDX_UPD:  begin offset = index_i;  upd_o = 1'b1; end
      default:     legal_o = 1'b0;
    endcase
  end

  // modulo 2^XLEN by width truncation
  assign addr_o = legal_o ? (base_i + offset) : '0;

endmodule

// File: rtl/lsu_agen_wb.sv
module lsu_agen_wb #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              req_i,
  input  logic              upd_i,
  input  logic              legal_i,
  input  logic [REG_AW-1:0] base_idx_i,
  input  logic [XLEN-1:0]   new_base_i,
  output logic              wb_en_o,
  output logic [REG_AW-1:0] wb_idx_o,
  output logic [XLEN-1:0]   wb_data_o
);

  // writing the zero register is dropped
  assign wb_en_o   = req_i & upd_i & legal_i & (base_idx_i != '0);
  assign wb_idx_o  = base_idx_i;
  assign wb_data_o = new_base_i;

endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_agen_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned REG_AW = 5,
  parameter int unsigned SH_W   = $clog2(XLEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [REG_AW-1:0] base_idx_i,
  input  logic [XLEN-1:0]   base_val_i,
  input  logic [REG_AW-1:0] index_idx_i,
  input  logic [XLEN-1:0]   index_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic              out_valid_o,
  output logic [XLEN-1:0]   addr_o,
  output logic              wb_en_o,
  output logic [REG_AW-1:0] wb_idx_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              illegal_o
);

  localparam int unsigned NUM_RD = 2;

  logic [NUM_RD-1:0][REG_AW-1:0] rd_idx;
  logic [NUM_RD-1:0][XLEN-1:0]   rd_val;
  logic [NUM_RD-1:0][XLEN-1:0]   rd_data;

  assign rd_idx[0] = base_idx_i;
  assign rd_idx[1] = index_idx_i;
  assign rd_val[0] = base_val_i;
  assign rd_val[1] = index_val_i;

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    lsu_agen_rf_read #(
      .XLEN  (XLEN),
      .REG_AW(REG_AW)
    ) u_rd (
      .idx_i (rd_idx[g]),
      .val_i (rd_val[g]),
      .data_o(rd_data[g])
    );
  end

  logic [XLEN-1:0] addr_d;
  logic            legal_d;
  logic            upd_d;

  lsu_agen_calc #(
    .XLEN (XLEN),
    .IMM_W(IMM_W),
    .SH_W (SH_W)
  ) u_calc (
    .mode_i (mode_i),
    .base_i (rd_data[0]),
    .index_i(rd_data[1]),
    .imm_i  (imm_i),
    .shamt_i(shamt_i),
    .addr_o (addr_d),
    .legal_o(legal_d),
    .upd_o  (upd_d)
  );

  logic              wb_en_d;
  logic [REG_AW-1:0] wb_idx_d;
  logic [XLEN-1:0]   wb_data_d;

  lsu_agen_wb #(
    .XLEN  (XLEN),
    .REG_AW(REG_AW)
  ) u_wb (
    .req_i     (in_valid_i),
    .upd_i     (upd_d),
    .legal_i   (legal_d),
    .base_idx_i(base_idx_i),
    .new_base_i(addr_d),
    .wb_en_o   (wb_en_d),
    .wb_idx_o  (wb_idx_d),
    .wb_data_o (wb_data_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      wb_en_o     <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      wb_en_o     <= wb_en_d;
      illegal_o   <= in_valid_i & ~legal_d;
    end
  end

  // payload only loads on accept; no reset needed
  always_ff @(posedge clk_i) begin
    if (in_valid_i) begin
      addr_o    <= addr_d;
      wb_idx_o  <= wb_idx_d;
      wb_data_o <= wb_data_d;
    end
  end

  p_wb_data_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_data_o == addr_o));

  p_wb_only_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> out_valid_o);

  p_accept_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_idle_no_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && !wb_en_o));

  p_no_zero_wb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o != '0));

  p_illegal_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wb_en_o && addr_o == '0));

  p_nonupd_no_wb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_i inside {3'b000, 3'b001, 3'b010}) |=> !wb_en_o);

endmodule

// File: tb/lsu_agen_tb.sv
module lsu_agen_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [4:0]  base_idx_i = '0;
  logic [31:0] base_val_i = '0;
  logic [4:0]  index_idx_i = '0;
  logic [31:0] index_val_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  shamt_i = '0;
  logic        out_valid_o;
  logic [31:0] addr_o;
  logic        wb_en_o;
  logic [4:0]  wb_idx_o;
  logic [31:0] wb_data_o;
  logic        illegal_o;

  always #2 clk_i = ~clk_i; // 250 MHz

  lsu_agen u_dut (
    .clk_i, .rst_ni, .in_valid_i, .mode_i, .base_idx_i, .base_val_i,
    .index_idx_i, .index_val_i, .imm_i, .shamt_i, .out_valid_o, .addr_o,
    .wb_en_o, .wb_idx_o, .wb_data_o, .illegal_o
  );

  typedef struct {
    logic [31:0] addr;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic        illegal;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;

  task automatic drive(input logic [2:0] m, input logic [4:0] bi, input logic [31:0] bv,
                       input logic [4:0] ii, input logic [31:0] iv,
                       input logic [15:0] im, input logic [4:0] sh, input string tag);
    exp_t e;
    logic [31:0] b, x, off;
    b = (bi == 0) ? 32'd0 : bv;
    x = (ii == 0) ? 32'd0 : iv;
    e.illegal = 1'b0;
    e.wb_en   = 1'b0;
    case (m)
      3'd0, 3'd3: off = {{16{im[15]}}, im};
      3'd1, 3'd4: off = x;
      3'd2:       off = x << sh;
      default: begin off = 0; e.illegal = 1'b1; end
    endcase
    e.addr   = e.illegal ? 32'd0 : b + off;
    e.wb_en  = (m == 3'd3 || m == 3'd4) && (bi != 0);
    e.wb_idx = bi;
    e.tag    = tag;
    @(posedge clk_i); #1;
    in_valid_i = 1'b1; mode_i = m; base_idx_i = bi; base_val_i = bv;
    index_idx_i = ii; index_val_i = iv; imm_i = im; shamt_i = sh;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i); #1;
      in_valid_i = 1'b0;
      mode_i = $urandom; base_idx_i = 5'd7; base_val_i = $urandom;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && out_valid_o) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: out_valid_o=1 with nothing pending (actual 1 expected 0)");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (addr_o !== e.addr || wb_en_o !== e.wb_en || illegal_o !== e.illegal ||
            (e.wb_en && (wb_idx_o !== e.wb_idx || wb_data_o !== e.addr))) begin
          n_fail++;
          $display("FAIL %s: addr=%h wb_en=%b wb_idx=%0d wb_data=%h ill=%b expected addr=%h wb_en=%b wb_idx=%0d wb_data=%h ill=%b",
                   e.tag, addr_o, wb_en_o, wb_idx_o, wb_data_o, illegal_o,
                   e.addr, e.wb_en, e.wb_idx, e.addr, e.illegal);
        end
      end
    end else if (rst_ni && wb_en_o) begin
      n_tests++; n_fail++;
      $display("FAIL R10: wb_en_o=1 while out_valid_o=0 (actual 1 expected 0)");
    end
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual timeout expected completion)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    in_valid_i = 1'b1; // held during reset: must not leak out
    repeat (3) @(negedge clk_i);
    n_tests++;
    if (out_valid_o !== 1'b0 || wb_en_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: valid=%b wb=%b ill=%b expected 0 0 0", out_valid_o, wb_en_o, illegal_o);
    end
    in_valid_i = 1'b0;
    rst_ni = 1'b1;

    drive(3'd0, 5'd3, 32'h0000_1000, 5'd4, 32'hDEAD_BEEF, 16'h0010, 5'd0, "R1 disp pos");
    drive(3'd0, 5'd3, 32'h0000_1000, 5'd4, 32'h0, 16'hFFF0, 5'd0, "R1 disp neg");
    drive(3'd0, 5'd5, 32'h1234_5678, 5'd0, 32'h0, 16'h0000, 5'd0, "R1 reg-indirect");
    drive(3'd1, 5'd2, 32'h0000_0100, 5'd9, 32'h0000_0023, 16'h7777, 5'd3, "R2 indexed");
    drive(3'd2, 5'd2, 32'h0000_1000, 5'd9, 32'h0000_0003, 16'h0, 5'd2, "R3 scaled sh2");
    drive(3'd2, 5'd2, 32'h0000_1000, 5'd9, 32'h0000_0003, 16'h0, 5'd0, "R3 scaled sh0");
    drive(3'd2, 5'd2, 32'h0000_0001, 5'd9, 32'h0000_0003, 16'h0, 5'd31, "R3 scaled sh31");
    idle(2);
    drive(3'd3, 5'd6, 32'h0000_2000, 5'd1, 32'h5555_5555, 16'h8000, 5'd0, "R4 disp upd");
    drive(3'd4, 5'd31, 32'h0000_4000, 5'd8, 32'h0000_0040, 16'h0, 5'd0, "R5 idx upd");
    drive(3'd0, 5'd0, 32'hFFFF_0000, 5'd1, 32'h0, 16'h0123, 5'd0, "R6 zero base absolute");
    drive(3'd1, 5'd4, 32'h0000_0400, 5'd0, 32'hAAAA_AAAA, 16'h0, 5'd0, "R6 zero index");
    drive(3'd3, 5'd0, 32'hCAFE_0000, 5'd1, 32'h0, 16'h0040, 5'd0, "R7 zero base disp upd");
    drive(3'd4, 5'd0, 32'hCAFE_0000, 5'd1, 32'h0000_0080, 16'h0, 5'd0, "R7 zero base idx upd");
    drive(3'd5, 5'd6, 32'h0000_2000, 5'd1, 32'h1, 16'h0004, 5'd0, "R8 mode5");
    drive(3'd6, 5'd6, 32'h0000_2000, 5'd1, 32'h1, 16'h0004, 5'd0, "R8 mode6");
    drive(3'd7, 5'd6, 32'h0000_2000, 5'd1, 32'h1, 16'h0004, 5'd0, "R8 mode7");
    drive(3'd1, 5'd3, 32'hFFFF_FFF0, 5'd4, 32'h0000_0020, 16'h0, 5'd0, "R9 wrap indexed");
    drive(3'd2, 5'd3, 32'h8000_0000, 5'd4, 32'h0000_0001, 16'h0, 5'd31, "R9 wrap scaled");
    drive(3'd3, 5'd7, 32'h0000_0008, 5'd1, 32'h0, 16'hFFF0, 5'd0, "R9 wrap disp upd");
    idle(3);
    n_tests++;
    if (out_valid_o !== 1'b0 || wb_en_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10: idle valid=%b wb=%b expected 0 0", out_valid_o, wb_en_o);
    end
    for (int i = 0; i < 40; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 4));
      drive(m, 5'($urandom), $urandom, 5'($urandom), $urandom, 16'($urandom), 5'($urandom),
            "R10 random stream");
      if (i % 7 == 3) idle(1);
    end
    idle(3);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d results missing (expected 0)", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule